// File: doc/BRIEF.md
# Serial Flash Status Register Write Handler

This block is the device-side logic of a serial flash that owns a 16-bit status register. The block oversamples the serial bus pins (chip select, serial clock, data in) with its own clock, so both serial clock polarities work: idle low and idle high. It decodes three commands, each sent MSB first. The first sets the write-enable latch. The second streams status byte 0 out on the data-out pin. The third loads new configuration bits into the register.

A status write is accepted only when two conditions hold at the moment chip select fell: the write-enable latch is set and no internal cycle is running. The host follows the opcode with one or two data bytes. Chip select must rise exactly after the 8th or 16th data bit. Any other length throws the command away. Only the configuration bits are loaded, and a one-byte write clears the two upper configuration bits.

An accepted write starts a busy period whose length is fixed by a parameter. While it runs, the host can poll the register over the bus. When the busy period ends, the busy flag and the write-enable latch clear together. The whole register is also visible on a parallel read port for the rest of the device.

Top module: `flash_sr_writer`

## Requirements
- R1: After synchronous reset the status read port is 0x0000 and the data-out enable is 0.
- R2: Opcode 0x06 followed by chip select rising after exactly 8 bits sets the write-enable latch (bit 1).
- R3: Opcode 0x01 has no effect on the register unless bit 1 was already 1 when chip select fell.
- R4: A write with exactly 8 data bits loads register bits 7..2 from data bits 7..2. It clears bits 9 and 8. Data bits 1..0 are ignored, and bits 15..10 stay 0.
- R5: A write with exactly 16 data bits also loads bit 9 from bit 1 of the second data byte and bit 8 from bit 0 of the second data byte. Bits 7..2 of the second data byte are ignored.
- R6: If chip select rises after any other number of data bits (0, 4, 12, 20 or 24), the configuration bits keep their value, bit 1 keeps its value, and no busy period starts.
- R7: An accepted write sets bit 0 (busy) for TW_CYCLES clock cycles, with bit 1 held at 1 throughout. Bits 0 and 1 then clear in the same cycle.
- R8: Opcode 0x05 shifts status byte 0 out MSB first, with data-out changing on serial clock falling edges. The byte is resampled at every byte boundary, so polling during a busy period returns bit 0 = 1.
- R9: The data-out enable is 0 at all times except during the data phase of opcode 0x05, and it is 0 throughout a write transfer.
- R10: An opcode 0x01 whose chip select fell while bit 0 was 1 is ignored, even if bit 1 is set.
- R11: Writes, write-enable and status reads behave the same with the serial clock idling high as with it idling low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock; samples the bus pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data from the host |
| do_o | output | 1 | Serial data to the host |
| do_en | output | 1 | Drive enable for do_o; 0 means high impedance |
| status_o | output | 16 | Current status register value |

## Verification
A status read can sample the register in the same clock cycle that the busy timer expires and clears both busy and the write-enable latch. To provoke this, the bench keeps chip select low after a valid write and polls five consecutive bytes across the end of the busy period. Every polled byte must show either both flags set or both flags clear, never a mix. The flags may change only once, from set to clear. The first byte must show them set and the last byte must show them clear.

// File: rtl/flash_sr_pkg.sv
// Shared constants and the request type passed from the command engine to
// the status register core. Assumes byte 0 carries busy/latch/config bits and
// byte 1 carries the two upper configuration bits in its low positions.
package flash_sr_pkg;

    localparam logic [7:0] OP_WR_ENABLE = 8'h06;
    localparam logic [7:0] OP_RD_STATUS = 8'h05;
    localparam logic [7:0] OP_WR_STATUS = 8'h01;

    localparam int SR_WIDTH    = 16;
    localparam int LO_CFG_BITS = 6;   // register bits 7..2
    localparam int HI_CFG_BITS = 2;   // register bits 9..8

    localparam int FRAME_BITS    = 8;
    localparam int ONE_BYTE_END  = 2 * FRAME_BITS;
    localparam int TWO_BYTE_END  = 3 * FRAME_BITS;

    typedef struct packed {
        logic                   set_latch;
        logic                   commit;
        logic                   two_byte;
        logic [LO_CFG_BITS-1:0] lo_cfg;
        logic [HI_CFG_BITS-1:0] hi_cfg;
    } sr_req_t;

endpackage

// File: rtl/fsr_pin_sync.sv
// Brings the asynchronous bus pins into the device clock domain through a
// parameterised flop chain, then derives edge strobes for chip select and the
// serial clock. Assumes each serial clock phase spans several device clocks.
module fsr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic di,
    output logic cs_q,
    output logic di_q,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise
);

    // Pipe word layout: {di, sclk, cs_n}
    logic [2:0] pipe [STAGES];
    logic       sclk_d;
    logic       cs_d;
    logic       sclk_s;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage captures the raw pins
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[g] <= 3'b001;
                    else        pipe[g] <= {di, sclk, cs_n};
                end
            end else begin : g_next
                // Later stages shift the captured word along
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[g] <= 3'b001;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign cs_q   = pipe[STAGES-1][0];
    assign sclk_s = pipe[STAGES-1][1];
    assign di_q   = pipe[STAGES-1][2];

    // Remember last synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            cs_d   <= cs_q;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign cs_fall   = ~cs_q & cs_d;
    assign cs_rise   = cs_q & ~cs_d;

endmodule

// File: rtl/fsr_cmd_engine.sv
// Counts bits of one chip-select frame, captures opcode and data bytes, and
// decides at chip-select rise whether a latch-set or status write is issued.
// Also serialises status byte 0 for the read command. Assumes synchronised
// inputs and single-cycle strobes from fsr_pin_sync.
module fsr_cmd_engine
    import flash_sr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_q,
    input  logic       di_q,
    input  logic       sclk_rise,
    input  logic       sclk_fall,
    input  logic       cs_fall,
    input  logic       cs_rise,
    input  logic [7:0] sr_lo,
    output sr_req_t    req,
    output logic       do_o,
    output logic       do_en
);

    localparam int CNT_W = $clog2(TWO_BYTE_END + 8) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] END_OP   = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] END_ONE  = CNT_W'(ONE_BYTE_END);
    localparam logic [CNT_W-1:0] END_TWO  = CNT_W'(TWO_BYTE_END);

    logic [CNT_W-1:0] bit_cnt;
    logic [7:0]       in_sh;
    logic [7:0]       in_next;
    logic [7:0]       opcode;
    logic [LO_CFG_BITS-1:0] lo_cfg_q;
    logic [HI_CFG_BITS-1:0] hi_cfg_q;
    logic             armed;
    logic             rd_active;
    logic [2:0]       rd_cnt;
    logic [7:0]       rd_sh;
    logic             do_q;

    assign in_next = {in_sh[6:0], di_q};

    // Bit counter, input shifter and field capture for the current frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            in_sh    <= '0;
            opcode   <= '0;
            lo_cfg_q <= '0;
            hi_cfg_q <= '0;
            armed    <= 1'b0;
        end else if (cs_fall) begin
            bit_cnt <= '0;
            armed   <= sr_lo[1] & ~sr_lo[0];
        end else if (sclk_rise && !cs_q) begin
            in_sh <= in_next;
            if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == END_OP - 1'b1)  opcode   <= in_next;
            if (bit_cnt == END_ONE - 1'b1) lo_cfg_q <= in_next[7:2];
            if (bit_cnt == END_TWO - 1'b1) hi_cfg_q <= in_next[1:0];
        end
    end

    // One-cycle request issued when chip select returns high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= '0;
        end else begin
            req.set_latch <= cs_rise && bit_cnt == END_OP && opcode == OP_WR_ENABLE;
            req.commit    <= cs_rise && armed && opcode == OP_WR_STATUS &&
                             (bit_cnt == END_ONE || bit_cnt == END_TWO);
            req.two_byte  <= bit_cnt == END_TWO;
            req.lo_cfg    <= lo_cfg_q;
            req.hi_cfg    <= hi_cfg_q;
        end
    end

    // Read phase flag: set once the read opcode is complete, cleared per frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_active <= 1'b0;
        end else if (cs_fall || cs_rise) begin
            rd_active <= 1'b0;
        end else if (sclk_rise && !cs_q && bit_cnt == END_OP - 1'b1) begin
            rd_active <= (in_next == OP_RD_STATUS);
        end
    end

    // Output shifter: reloads status byte 0 at every byte boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt <= '0;
            rd_sh  <= '0;
            do_q   <= 1'b0;
        end else if (cs_fall) begin
            rd_cnt <= '0;
        end else if (sclk_fall && rd_active && !cs_q) begin
            rd_cnt <= rd_cnt + 1'b1;
            if (rd_cnt == 3'd0) begin
                do_q  <= sr_lo[7];
                rd_sh <= {sr_lo[6:0], 1'b0};
            end else begin
                do_q  <= rd_sh[7];
                rd_sh <= {rd_sh[6:0], 1'b0};
            end
        end
    end

    assign do_o  = do_q;
    assign do_en = rd_active & ~cs_q;

endmodule

// File: rtl/fsr_status_core.sv
// Holds the status register, applies accepted writes to the configuration
// bits only, and runs the busy timer. Assumes requests are pre-qualified by
// the command engine except for the busy interlock on latch setting.
module fsr_status_core
    import flash_sr_pkg::*;
#(
    parameter int TW_CYCLES = 50000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  sr_req_t             req,
    output logic [SR_WIDTH-1:0] sr
);

    localparam int TMR_W = $clog2(TW_CYCLES + 1);
    localparam int PAD_W = SR_WIDTH - HI_CFG_BITS - LO_CFG_BITS - 2;

    logic [LO_CFG_BITS-1:0] lo_cfg;
    logic [HI_CFG_BITS-1:0] hi_cfg;
    logic                   wel;
    logic                   busy;
    logic [TMR_W-1:0]       timer;

    // Register update: timer expiry, then write commit, then latch set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cfg <= '0;
            hi_cfg <= '0;
            wel    <= 1'b0;
            busy   <= 1'b0;
            timer  <= '0;
        end else if (busy) begin
            timer <= timer - 1'b1;
            if (timer == TMR_W'(1)) begin
                busy <= 1'b0;
                wel  <= 1'b0;
            end
        end else if (req.commit) begin
            lo_cfg <= req.lo_cfg;
            hi_cfg <= req.two_byte ? req.hi_cfg : '0;
            busy   <= 1'b1;
            timer  <= TMR_W'(TW_CYCLES);
        end else if (req.set_latch) begin
            wel <= 1'b1;
        end
    end

    assign sr = {{PAD_W{1'b0}}, hi_cfg, lo_cfg, wel, busy};

endmodule

// File: rtl/flash_sr_writer.sv
// Top of the status register write handler: pin synchroniser, command
// engine and register core. Assumes clk is several times faster than sclk.
module flash_sr_writer
    import flash_sr_pkg::*;
#(
    parameter int TW_CYCLES   = 50000,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        sclk,
    input  logic        di,
    output logic        do_o,
    output logic        do_en,
    output logic [15:0] status_o
);

    logic    cs_q, di_q, sclk_rise, sclk_fall, cs_fall, cs_rise;
    sr_req_t req;
    logic [SR_WIDTH-1:0] sr;

    fsr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .di        (di),
        .cs_q      (cs_q),
        .di_q      (di_q),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise)
    );

    fsr_cmd_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_q      (cs_q),
        .di_q      (di_q),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .sr_lo     (sr[7:0]),
        .req       (req),
        .do_o      (do_o),
        .do_en     (do_en)
    );

    fsr_status_core #(.TW_CYCLES(TW_CYCLES)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .sr    (sr)
    );

    assign status_o = sr;

endmodule

// File: rtl/flash_sr_writer_chk.sv
// Temporal checks on the status register handler, bound to the top module.
// Assumes SYNC_STAGES matches the synchroniser depth of the bound instance.
module flash_sr_writer_chk #(
    parameter int TW_CYCLES   = 50000,
    parameter int SYNC_STAGES = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       do_en,
    input logic [9:0] status
);

    logic [31:0] busy_run;
    logic [7:0]  hi_run;

    // Length of the current busy period in clock cycles
    always_ff @(posedge clk) begin
        if (!rst_n)         busy_run <= '0;
        else if (status[0]) busy_run <= busy_run + 1'b1;
        else                busy_run <= '0;
    end

    // Consecutive cycles with chip select high, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                 hi_run <= '0;
        else if (!cs_n)             hi_run <= '0;
        else if (hi_run != 8'hFF)   hi_run <= hi_run + 1'b1;
    end

    AST_BUSY_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(status[1])); // R3

    AST_CFG_HELD_UNLESS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(status[0]) |-> $stable(status[9:2])); // R6

    AST_LATCH_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |-> status[1]); // R7

    AST_BUSY_END_CLEARS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> !status[1]); // R7

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> busy_run == 32'(TW_CYCLES)); // R7

    AST_DO_RELEASED_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(hi_run) > 32'(SYNC_STAGES)) |-> !do_en); // R9

endmodule

bind flash_sr_writer flash_sr_writer_chk #(
    .TW_CYCLES   (TW_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .do_en  (do_en),
    .status (status_o[9:0])
);

// File: tb/flash_sr_writer_tb.sv
`timescale 1ns/1ps
module flash_sr_writer_tb;

    localparam int TW   = 300;
    localparam int HALF = 8;
    localparam int SETTLE = TW + 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        di = 1'b0;
    logic        do_o;
    logic        do_en;
    logic [15:0] status_o;

    int checks = 0;
    int fails  = 0;
    bit doen_seen = 1'b0;

    always #2 clk = ~clk;

    flash_sr_writer #(.TW_CYCLES(TW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .di(di),
        .do_o(do_o), .do_en(do_en), .status_o(status_o)
    );

    // {send_wren, data_bits, byte1, byte2, expected status after settling}
    localparam logic [37:0] VEC [10] = '{
        {1'b1, 5'd8,  8'hFF, 8'h00, 16'h00FC},  // R4 all config bits
        {1'b1, 5'd16, 8'h00, 8'hFF, 16'h0300},  // R5 upper bits, rest of byte ignored
        {1'b1, 5'd8,  8'hA4, 8'h00, 16'h00A4},  // R4 one byte clears bits 9..8
        {1'b0, 5'd16, 8'h00, 8'h03, 16'h00A4},  // R3 latch clear: ignored
        {1'b1, 5'd12, 8'h00, 8'h00, 16'h00A6},  // R6 12 bits cancel
        {1'b0, 5'd20, 8'h00, 8'h00, 16'h00A6},  // R6 20 bits cancel
        {1'b0, 5'd16, 8'h5B, 8'h02, 16'h0258},  // R5 latch still set from before
        {1'b1, 5'd0,  8'h00, 8'h00, 16'h025A},  // R6 opcode only
        {1'b0, 5'd24, 8'h00, 8'h00, 16'h025A},  // R6 24 bits cancel
        {1'b0, 5'd8,  8'h03, 8'h00, 16'h0000}   // R4 data bits 1..0 ignored
    };

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One chip-select frame of nbits bits, MSB first from tx[63]
    task automatic xfer(input logic [63:0] tx, input int nbits, input bit m3,
                        output logic [63:0] rx);
        rx = '0;
        sclk = m3;
        wclk(4);
        cs_n = 1'b0;
        wclk(HALF);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            di = tx[63-i];
            wclk(HALF);
            sclk = 1'b1;
            rx = {rx[62:0], do_o};
            if (do_en) doen_seen = 1'b1;
            wclk(HALF);
        end
        if (!m3) sclk = 1'b0;
        wclk(HALF);
        cs_n = 1'b1;
        wclk(2 * HALF);
    endtask

    task automatic wren(input bit m3);
        logic [63:0] rx;
        xfer({8'h06, 56'h0}, 8, m3, rx);
    endtask

    task automatic wrsr(input logic [7:0] b1, input logic [7:0] b2, input int nd, input bit m3);
        logic [63:0] rx;
        xfer({8'h01, b1, b2, 40'h0}, 8 + nd, m3, rx);
    endtask

    initial begin
        logic [63:0] rx;
        logic [7:0]  pb;
        bit          cleared;

        wclk(5);
        check("R1 reset status", 32'(status_o), 32'h0);
        check("R1 reset do_en", 32'(do_en), 32'h0);
        rst_n = 1'b1;
        wclk(5);

        for (int v = 0; v < 10; v++) begin
            if (VEC[v][37]) begin
                wren(1'b0);
                wclk(4);
                check($sformatf("R2 latch set vec %0d", v), 32'(status_o[1]), 32'h1);
            end
            doen_seen = 1'b0;
            wrsr(VEC[v][31:24], VEC[v][23:16], int'(VEC[v][36:32]), 1'b0);
            check($sformatf("R9 no drive in write vec %0d", v), 32'(doen_seen), 32'h0);
            wclk(SETTLE);
            check($sformatf("R4/R5/R6 vec %0d", v), 32'(status_o), 32'(VEC[v][15:0]));
        end

        // R10: write started while busy is ignored
        wren(1'b0);
        wrsr(8'h48, 8'h00, 8, 1'b0);
        check("R10 busy before second write", 32'(status_o[0]), 32'h1);
        wrsr(8'hC0, 8'h03, 16, 1'b0);
        wclk(SETTLE);
        check("R10 busy-time write ignored", 32'(status_o), 32'h0048);

        // R7: busy length and joint clearing of busy and latch
        wren(1'b0);
        wrsr(8'h3C, 8'h00, 8, 1'b0);
        wclk(TW - 40);
        check("R7 busy near end", 32'(status_o), 32'h003F);
        wclk(50);
        check("R7 after busy", 32'(status_o), 32'h003C);

        // R8: poll across the end of the busy period
        wren(1'b0);
        wrsr(8'h14, 8'h00, 8, 1'b0);
        xfer({8'h05, 56'h0}, 48, 1'b0, rx);
        cleared = 1'b0;
        for (int k = 0; k < 5; k++) begin
            pb = rx[39 - 8*k -: 8];
            if (pb == 8'h14) cleared = 1'b1;
            if (k == 0)
                check("R8 first poll busy", 32'(pb), 32'h17);
            else if (k == 4)
                check("R8 last poll idle", 32'(pb), 32'h14);
            else
                check($sformatf("R8 poll %0d consistent", k), 32'(pb), cleared ? 32'h14 : 32'h17);
        end
        wclk(SETTLE);
        check("R7 final after poll", 32'(status_o), 32'h0014);

        // R11: idle-high serial clock
        wren(1'b1);
        wclk(4);
        check("R11 latch set idle-high", 32'(status_o), 32'h0016);
        wrsr(8'h90, 8'h00, 8, 1'b1);
        wclk(SETTLE);
        check("R11 write idle-high", 32'(status_o), 32'h0090);
        doen_seen = 1'b0;
        xfer({8'h05, 56'h0}, 16, 1'b1, rx);
        check("R11 read idle-high", 32'(rx[7:0]), 32'h90);
        check("R8 read drives data-out", 32'(doen_seen), 32'h1);
        check("R9 released after read", 32'(do_en), 32'h0);

        // R1: reset in the middle of a busy period
        wren(1'b0);
        wrsr(8'hFC, 8'h00, 8, 1'b0);
        rst_n = 1'b0;
        wclk(3);
        check("R1 reset during busy", 32'(status_o), 32'h0);
        rst_n = 1'b1;
        wclk(3);
        check("R1 do_en after reset", 32'(do_en), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wclk(190000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule